// File: doc/BRIEF.md
# I2C master status flag register

This block keeps the status byte of a single-master I2C controller. A byte-level bus engine reports what happened on the wire through single-cycle event strobes: a start was generated, a byte went out, a byte came in, an acknowledge was missing, the address byte was sent, a stop was generated. The block turns these strobes into sticky flags. The CPU sees them through an 8-bit read-only status byte. The flags also drive a level interrupt request and a clock-stretch request, which the pin logic uses to hold SCL low while software has not yet serviced a finished byte.

Software clears most flags with a two-step access. It first reads the status byte while the flag is set, and then accesses the data register in the way that matches the flag: a write after a start or a transmitted byte, a read after a received byte. Any other access in between cancels the pending clear. Dropping the peripheral enable wipes every flag at once. All inputs are plain level or pulse signals. There is no streaming data path, so no valid/ready handshake is involved.

Top module: `i2c_stat_flags`

## Requirements
- R1: After reset the status byte is 00h. Bits 6, 4 and 2 always read 0. The fields are: bit7 event summary, bit5 direction (1 = transmitted), bit3 byte finished, bit1 master active, bit0 start done.
- R2: A start-generated strobe sets bit0 on the next cycle. Bit0 clears only after a status read followed by a data-register write.
- R3: A byte-transmitted strobe sets bit3 and sets bit5 to 1. That byte-finished flag clears only after a status read followed by a data-register write.
- R4: A byte-received strobe sets bit3 with bit5 at 0, provided the acknowledge-enable input is 1; otherwise the strobe is ignored. That flag clears only after a status read followed by a data-register read.
- R5: Bit5 is never 1 while bit3 is 0. Bit5 drops in the same cycle that bit3 clears.
- R6: `scl_hold` equals bit3 at all times.
- R7: A start request sets bit1. A stop-generated strobe clears bit1, and a simultaneous start request wins.
- R8: Bit7 is the OR of bit0, bit3, a pending acknowledge failure and a pending address-sent event. A pending acknowledge failure clears on a read of the second status register. A pending address-sent event clears after a status read followed by a data-register write.
- R9: While `pe` is 0, every flag reads 0 from the next cycle on, and event strobes are ignored.
- R10: `irq` is 1 exactly while `ite` is 1 and bit0 or bit3 is set. An acknowledge failure or an address-sent event alone never raises it.
- R11: A data-register access with no status read before it clears nothing. Any other access between the status read and the matching data access cancels the clear.
- R12: When a set strobe arrives in the same cycle as the access that would clear its flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pe | input | 1 | Peripheral enable; 0 forces all flags to 0 |
| ite | input | 1 | Interrupt enable |
| ack_en | input | 1 | Acknowledge enable for received bytes |
| req_start | input | 1 | Software start request (enters master mode) |
| ev_start | input | 1 | Engine: start condition generated |
| ev_tx_byte | input | 1 | Engine: byte transmitted, acknowledge pulse received |
| ev_rx_byte | input | 1 | Engine: byte received, acknowledge pulse sent |
| ev_ack_fail | input | 1 | Engine: no acknowledge after a byte |
| ev_addr_sent | input | 1 | Engine: address byte sent successfully |
| ev_stop | input | 1 | Engine: stop condition generated |
| sr1_rd | input | 1 | CPU read of the status byte |
| sr2_rd | input | 1 | CPU read of the second status register |
| dr_rd | input | 1 | CPU read of the data register |
| dr_wr | input | 1 | CPU write of the data register |
| status | output | 8 | Status byte |
| irq | output | 1 | Level interrupt request |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The bench builds the block with its default `RX_NEEDS_ACK = 1`. With that setting, received bytes that arrive while acknowledge is disabled are filtered, so both branches of the receive rule can be reached. Directed sequences walk each clear path with the correct access, the wrong access and an interleaved access. They also cover the set-versus-clear collision and enable removal. Seeded random traffic then mixes events, accesses and enable drops, so that several flags stay armed at the same time and interact.

// File: rtl/i2csf_pkg.sv
package i2csf_pkg;
  localparam int STAT_W  = 8;
  localparam int B_EVF   = 7;
  localparam int B_TRA   = 5;
  localparam int B_BTF   = 3;
  localparam int B_MSL   = 1;
  localparam int B_SB    = 0;
  localparam int NSEQ    = 3;
  localparam int SEQ_SB  = 0;
  localparam int SEQ_BTF = 1;
  localparam int SEQ_ADR = 2;
endpackage

// File: rtl/i2csf_seq_flag.sv
// Sticky flag cleared by a status read followed by a matching data access.
module i2csf_seq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set_i,
  input  logic arm_rd_i,
  input  logic match_i,
  input  logic other_i,
  output logic flag_o,
  output logic clr_o
);
  logic armed_q;

  assign clr_o = en & flag_o & armed_q & match_i & ~set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else if (!en) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else if (set_i) begin
      flag_o  <= 1'b1;
      armed_q <= 1'b0;
    end else if (clr_o) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else if (flag_o && arm_rd_i) begin
      armed_q <= 1'b1;
    end else if (other_i || match_i) begin
      armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/i2csf_sc_flag.sv
// Set/clear flag, set has priority, forced low while disabled.
module i2csf_sc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (!en)    flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2csf_pkg::*;
#(
  parameter bit RX_NEEDS_ACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pe,
  input  logic              ite,
  input  logic              ack_en,
  input  logic              req_start,
  input  logic              ev_start,
  input  logic              ev_tx_byte,
  input  logic              ev_rx_byte,
  input  logic              ev_ack_fail,
  input  logic              ev_addr_sent,
  input  logic              ev_stop,
  input  logic              sr1_rd,
  input  logic              sr2_rd,
  input  logic              dr_rd,
  input  logic              dr_wr,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic              scl_hold
);
  logic [NSEQ-1:0] set_v, match_v, other_v, flag_v, clr_v;
  logic tra_q, af_q, msl_q, rx_ok;
  logic any_acc;

  assign rx_ok   = ev_rx_byte & (ack_en | ~RX_NEEDS_ACK);
  assign any_acc = sr2_rd | dr_rd | dr_wr;

  assign set_v[SEQ_SB]    = ev_start;
  assign set_v[SEQ_BTF]   = ev_tx_byte | rx_ok;
  assign set_v[SEQ_ADR]   = ev_addr_sent;
  assign match_v[SEQ_SB]  = dr_wr;
  assign match_v[SEQ_BTF] = tra_q ? dr_wr : dr_rd;
  assign match_v[SEQ_ADR] = dr_wr;

  generate
    for (genvar i = 0; i < NSEQ; i++) begin : g_seq
      assign other_v[i] = any_acc & ~match_v[i];
      i2csf_seq_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (pe),
        .set_i    (set_v[i]),
        .arm_rd_i (sr1_rd),
        .match_i  (match_v[i]),
        .other_i  (other_v[i]),
        .flag_o   (flag_v[i]),
        .clr_o    (clr_v[i])
      );
    end
  endgenerate

  // Direction of the last finished byte; dropped together with the flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               tra_q <= 1'b0;
    else if (!pe)             tra_q <= 1'b0;
    else if (ev_tx_byte)      tra_q <= 1'b1;
    else if (rx_ok)           tra_q <= 1'b0;
    else if (clr_v[SEQ_BTF])  tra_q <= 1'b0;
  end

  i2csf_sc_flag u_af (
    .clk (clk), .rst_n (rst_n), .en (pe),
    .set_i (ev_ack_fail), .clr_i (sr2_rd), .flag_o (af_q)
  );

  i2csf_sc_flag u_msl (
    .clk (clk), .rst_n (rst_n), .en (pe),
    .set_i (req_start), .clr_i (ev_stop), .flag_o (msl_q)
  );

  always_comb begin
    status        = '0;
    status[B_SB]  = flag_v[SEQ_SB];
    status[B_MSL] = msl_q;
    status[B_BTF] = flag_v[SEQ_BTF];
    status[B_TRA] = tra_q;
    status[B_EVF] = |{flag_v, af_q};
  end

  assign irq      = ite & (flag_v[SEQ_SB] | flag_v[SEQ_BTF]);
  assign scl_hold = flag_v[SEQ_BTF];
endmodule

// File: rtl/i2csf_checker.sv
module i2csf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pe,
  input logic       ite,
  input logic       req_start,
  input logic       ev_start,
  input logic       ev_stop,
  input logic [7:0] status,
  input logic       irq,
  input logic       scl_hold
);
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] == 1'b0) && (status[4] == 1'b0) && (status[2] == 1'b0));

  p_start_sets_sb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pe && ev_start) |=> status[0]);

  p_tra_needs_btf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] |-> status[3]);

  p_hold_follows_btf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold == status[3]);

  p_stop_ends_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pe && ev_stop && !req_start) |=> !status[1]);

  p_evf_covers_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] || status[3]) |-> status[7]);

  p_disable_wipes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pe |=> (status == 8'h00));

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ite && status[7]));
endmodule

bind i2c_stat_flags i2csf_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pe        (pe),
  .ite       (ite),
  .req_start (req_start),
  .ev_start  (ev_start),
  .ev_stop   (ev_stop),
  .status    (status),
  .irq       (irq),
  .scl_hold  (scl_hold)
);

// File: tb/sim_i2c_stat_flags.sv
`timescale 1ns/1ps
module sim_i2c_stat_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pe = 1'b0, ite = 1'b0, ack_en = 1'b0, req_start = 1'b0;
  logic ev_start = 1'b0, ev_tx_byte = 1'b0, ev_rx_byte = 1'b0;
  logic ev_ack_fail = 1'b0, ev_addr_sent = 1'b0, ev_stop = 1'b0;
  logic sr1_rd = 1'b0, sr2_rd = 1'b0, dr_rd = 1'b0, dr_wr = 1'b0;
  logic [7:0] status;
  logic irq, scl_hold;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of the flags
  logic m_sb, m_sba, m_btf, m_btfa, m_tra, m_adr, m_adra, m_af, m_msl;

  always #5 clk = ~clk;

  i2c_stat_flags u0 (
    .clk (clk), .rst_n (rst_n), .pe (pe), .ite (ite), .ack_en (ack_en),
    .req_start (req_start), .ev_start (ev_start), .ev_tx_byte (ev_tx_byte),
    .ev_rx_byte (ev_rx_byte), .ev_ack_fail (ev_ack_fail),
    .ev_addr_sent (ev_addr_sent), .ev_stop (ev_stop), .sr1_rd (sr1_rd),
    .sr2_rd (sr2_rd), .dr_rd (dr_rd), .dr_wr (dr_wr), .status (status),
    .irq (irq), .scl_hold (scl_hold)
  );

  // two-step clear rule from R2/R3/R4/R11/R12: returns {flag, armed}
  function automatic logic [1:0] seq_next(logic f, logic a, logic s, logic m);
    logic o;
    o = (sr2_rd | dr_rd | dr_wr) & ~m;
    if (s)                 return 2'b10;
    if (f && a && m)       return 2'b00;
    if (f && sr1_rd)       return 2'b11;
    if (o || m)            return {f, 1'b0};
    return {f, a};
  endfunction

  function automatic logic [7:0] m_status();
    return {m_sb | m_btf | m_af | m_adr, 1'b0, m_tra, 1'b0, m_btf, 1'b0, m_msl, m_sb};
  endfunction

  task automatic model_zero();
    {m_sb, m_sba, m_btf, m_btfa, m_tra, m_adr, m_adra, m_af, m_msl} = '0;
  endtask

  task automatic step();
    logic [1:0] nsb, nbtf, nadr;
    logic rxok, ntra, naf, nmsl;
    rxok = ev_rx_byte & ack_en;
    nsb  = seq_next(m_sb, m_sba, ev_start, dr_wr);
    nbtf = seq_next(m_btf, m_btfa, ev_tx_byte | rxok, m_tra ? dr_wr : dr_rd);
    nadr = seq_next(m_adr, m_adra, ev_addr_sent, dr_wr);
    ntra = ev_tx_byte ? 1'b1 : (rxok ? 1'b0 : (nbtf[1] ? m_tra : 1'b0));
    naf  = ev_ack_fail ? 1'b1 : (sr2_rd ? 1'b0 : m_af);
    nmsl = req_start ? 1'b1 : (ev_stop ? 1'b0 : m_msl);
    @(posedge clk);
    #1;
    if (!pe) model_zero();
    else begin
      {m_sb, m_sba} = nsb; {m_btf, m_btfa} = nbtf; {m_adr, m_adra} = nadr;
      m_tra = ntra; m_af = naf; m_msl = nmsl;
    end
    {req_start, ev_start, ev_tx_byte, ev_rx_byte, ev_ack_fail, ev_addr_sent, ev_stop} = '0;
    {sr1_rd, sr2_rd, dr_rd, dr_wr} = '0;
  endtask

  // irq per R10, scl_hold per R6
  task automatic check(input string req, input logic [7:0] es);
    logic ei, eh;
    ei = ite & (es[0] | es[3]);
    eh = es[3];
    checks++;
    if (status !== es || irq !== ei || scl_hold !== eh) begin
      fails++;
      $display("FAIL %s: status=%02h irq=%0b hold=%0b expected status=%02h irq=%0b hold=%0b",
               req, status, irq, scl_hold, es, ei, eh);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    model_zero();
    #23; rst_n = 1'b1;
    #1;
    check("R1 reset", 8'h00);
    pe = 1'b1; ite = 1'b1; ack_en = 1'b1;
    req_start = 1'b1; step(); check("R7 start request", 8'h02);
    ev_start = 1'b1;  step(); check("R2 R10 start done", 8'h83);
    dr_wr = 1'b1;     step(); check("R11 write without read", 8'h83);
    sr1_rd = 1'b1;    step();
    sr2_rd = 1'b1;    step();
    dr_wr = 1'b1;     step(); check("R11 interleaved access", 8'h83);
    sr1_rd = 1'b1;    step();
    dr_wr = 1'b1;     step(); check("R2 sb cleared", 8'h02);
    ev_addr_sent = 1'b1; step(); check("R8 R10 address sent", 8'h82);
    ev_tx_byte = 1'b1;   step(); check("R3 R6 byte sent", 8'hAA);
    sr1_rd = 1'b1;    step();
    dr_rd = 1'b1;     step(); check("R3 wrong access", 8'hAA);
    sr1_rd = 1'b1;    step();
    dr_wr = 1'b1; ev_tx_byte = 1'b1; step(); check("R12 set beats clear", 8'hAA);
    sr1_rd = 1'b1;    step();
    dr_wr = 1'b1;     step(); check("R3 R5 btf cleared", 8'h02);
    ev_rx_byte = 1'b1; step(); check("R4 byte received", 8'h8A);
    sr1_rd = 1'b1;    step();
    dr_wr = 1'b1;     step(); check("R4 wrong access", 8'h8A);
    sr1_rd = 1'b1;    step();
    dr_rd = 1'b1;     step(); check("R4 R5 rx cleared", 8'h02);
    ack_en = 1'b0; ev_rx_byte = 1'b1; step(); check("R4 no ack enable", 8'h02);
    ack_en = 1'b1;
    ev_ack_fail = 1'b1; step(); check("R8 R10 ack failure", 8'h82);
    sr1_rd = 1'b1;    step();
    dr_rd = 1'b1;     step(); check("R8 failure needs sr2", 8'h82);
    sr2_rd = 1'b1;    step(); check("R8 failure cleared", 8'h02);
    ite = 1'b0; ev_start = 1'b1; step(); check("R10 ite off", 8'h83);
    ev_stop = 1'b1;   step(); check("R7 stop", 8'h81);
    ev_tx_byte = 1'b1; step(); check("R3 tx while sb", 8'hA9);
    pe = 1'b0;        step(); check("R9 disable", 8'h00);
    ev_start = 1'b1;  step(); check("R9 events ignored", 8'h00);
    pe = 1'b1; ite = 1'b1;

    void'($urandom(32'd4242));
    for (int n = 0; n < 4000; n++) begin
      int ev, acc;
      pe     = ($urandom % 100) >= 2;
      ite    = ($urandom % 4) != 0;
      ack_en = ($urandom % 4) != 0;
      req_start = ($urandom % 20) == 0;
      ev  = $urandom % 10;
      acc = $urandom % 8;
      case (ev)
        0: ev_start = 1'b1;
        1: ev_tx_byte = 1'b1;
        2: ev_rx_byte = 1'b1;
        3: ev_ack_fail = 1'b1;
        4: ev_addr_sent = 1'b1;
        5: ev_stop = 1'b1;
        default: ;
      endcase
      case (acc)
        0, 1: sr1_rd = 1'b1;
        2: sr2_rd = 1'b1;
        3: dr_rd = 1'b1;
        4: dr_wr = 1'b1;
        default: ;
      endcase
      step();
      check("R2 R3 R4 R8 R9 random", m_status());
    end
    finish_run();
  end
endmodule